// File: doc/BRIEF.md
# Acquisition Interrupt Control Register

This block is a single 32-bit control and status register for a data-acquisition front end. It drives one interrupt line. The main interrupt source is either a DMA-complete pulse or the input FIFO occupancy crossing a programmable threshold, and a mode bit picks between the two. Two external digital trigger inputs each have their own enable bit and a sticky status flag. The register also stores two analog capture mode selects, one for post-trigger capture and one for pre-trigger capture.

Software writes configuration through a simple write port and reads the whole register back at any time. All status flags are sticky and are cleared by writing a 1 to the flag's bit position. The FIFO occupancy is an input count. Each trigger input passes through a two-stage synchronizer before its edge is detected.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00000C08 and `irq_o` is 0.
- R2: Bits 3, 10 and 11 always read 1, and bits 31:16 always read 0. Writes do not change them.
- R3: These configuration fields read back the last value written to them:
  - bit 0: main interrupt enable.
  - bit 2: source select (1 = DMA, 0 = FIFO level).
  - bits 7:4: level code.
  - bit 8: post-trigger capture select.
  - bit 9: pre-trigger capture select.
  - bit 12: trigger 0 enable.
  - bit 14: trigger 1 enable.
- R4: The level code selects the FIFO threshold: codes 0 to 6 give 32, 64, 128, 256, 512, 1024 and 1536 entries, and codes 7 to 15 give 32. In FIFO mode with bit 0 set, status bit 1 sets on the clock edge at which `fifo_count >= threshold` first holds. It does not set while the count is below the threshold.
- R5: The FIFO-level status sets once per crossing. After it is cleared while the count stays at or above the threshold, it stays 0. The count must drop below the threshold and rise again before the status sets again.
- R6: In DMA mode (bit 2 = 1) with bit 0 set, a `dma_done` pulse sets bit 1 at the next clock edge. FIFO crossings do not set bit 1 in DMA mode, and `dma_done` does not set bit 1 in FIFO mode.
- R7: While bit 0 is 0, neither source sets bit 1, and `irq_o` stays 0 unless a trigger interrupt is pending and enabled.
- R8: A rising edge on `ext_trig[n]` sets status bit 13 (n = 0) or bit 15 (n = 1) on the third clock edge after the change, but only when that trigger's enable is 1. A level held high does not set the status again.
- R9: Writing 1 to bit 1, 13 or 15 clears that status flag, and writing 0 leaves it unchanged. When a set event and a clearing write fall on the same edge, the flag ends up set.
- R10: `irq_o` is high exactly when some status flag is set and its own enable (bit 0, 12 or 14) is 1. Clearing an enable lowers `irq_o` but leaves the status flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| fifo_count | input | CNT_W | FIFO occupancy in entries |
| dma_done | input | 1 | One-cycle DMA-complete pulse |
| ext_trig | input | 2 | Asynchronous external trigger inputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all sixteen level codes and, for each code, places the count one entry below the threshold and then exactly at it. A decoder with a wrong table entry, or a comparator off by one, shows up as a flag set early or set late.

It also clears the FIFO flag while the count stays above the threshold. A level-sensitive design would set the flag again at once, where an edge-sensitive one keeps it clear. It then lines up a crossing with a clearing write on the same edge; a design that gives the clear priority would lose that event.

The trigger checks sample on the exact edge at which the status should first appear, so a missing or extra synchronizer stage shows up. They also raise a trigger while its enable is off, then set the enable while the input is still high. An ungated or level-sensitive design would raise the status in that case.

// File: rtl/acq_irq_pkg.sv
package acq_irq_pkg;
    localparam int REG_W    = 32;
    localparam int CODE_W   = 4;
    localparam int NTRIG    = 2;

    // Bit positions software relies on
    localparam int B_IEN    = 0;
    localparam int B_IST    = 1;
    localparam int B_SRC    = 2;
    localparam int B_ONE0   = 3;
    localparam int B_CODE   = 4;
    localparam int B_POST   = 8;
    localparam int B_PRE    = 9;
    localparam int B_ONE1   = 10;
    localparam int B_ONE2   = 11;
    localparam int B_TRIG   = 12;  // trigger n enable at B_TRIG+2n, status at +1

    typedef struct packed {
        logic                 ien;
        logic                 src_dma;
        logic [CODE_W-1:0]    code;
        logic                 post_sel;
        logic                 pre_sel;
        logic [NTRIG-1:0]     trg_en;
        logic [NTRIG-1:0]     trg_st;
        logic                 main_st;
        logic                 lvl_hit;
    } ctrl_t;
endpackage

// File: rtl/acq_thr_dec.sv
module acq_thr_dec #(
    parameter int CODE_W   = 4,
    parameter int TW       = 13,
    parameter int BASE_THR = 32
) (
    input  logic [CODE_W-1:0] code,
    output logic [TW-1:0]     thr
);
    localparam logic [TW-1:0] BASE_V = TW'(BASE_THR);
    localparam logic [TW-1:0] TOP_V  = TW'(BASE_THR * 48);

    always_comb begin
        if (code <= CODE_W'(5)) begin
            thr = BASE_V << code[2:0];
        end else if (code == CODE_W'(6)) begin
            thr = TOP_V;
        end else begin
            thr = BASE_V;
        end
    end
endmodule

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[0] <= 1'b0;
        else        ff_q[0] <= din;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[i] <= 1'b0;
            else        ff_q[i] <= ff_q[i-1];
        end
    end

    assign rise = ff_q[STAGES-1] & ~ff_q[STAGES];
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
    import acq_irq_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int BASE_THR    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             dma_done,
    input  logic [1:0]       ext_trig,
    output logic             irq_o
);
    localparam int TW = CNT_W + 1;

    ctrl_t           ctl_d, ctl_q;
    logic [TW-1:0]   thr;
    logic            hit;
    logic            evt_main;
    logic [NTRIG-1:0] trg_rise;

    acq_thr_dec #(.CODE_W(CODE_W), .TW(TW), .BASE_THR(BASE_THR)) u_thr (
        .code (ctl_q.code),
        .thr  (thr)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        acq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (ext_trig[g]),
            .rise  (trg_rise[g])
        );
    end

    assign hit      = ({1'b0, fifo_count} >= thr);
    assign evt_main = ctl_q.src_dma ? dma_done : (hit & ~ctl_q.lvl_hit);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.lvl_hit = hit;
        if (reg_we) begin
            ctl_d.ien      = reg_wdata[B_IEN];
            ctl_d.src_dma  = reg_wdata[B_SRC];
            ctl_d.code     = reg_wdata[B_CODE +: CODE_W];
            ctl_d.post_sel = reg_wdata[B_POST];
            ctl_d.pre_sel  = reg_wdata[B_PRE];
            if (reg_wdata[B_IST]) ctl_d.main_st = 1'b0;
            for (int n = 0; n < NTRIG; n++) begin
                ctl_d.trg_en[n] = reg_wdata[B_TRIG + 2*n];
                if (reg_wdata[B_TRIG + 2*n + 1]) ctl_d.trg_st[n] = 1'b0;
            end
        end
        // set events win over a clearing write on the same edge
        if (ctl_q.ien && evt_main) ctl_d.main_st = 1'b1;
        for (int n = 0; n < NTRIG; n++) begin
            if (ctl_q.trg_en[n] && trg_rise[n]) ctl_d.trg_st[n] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[B_IEN]            = ctl_q.ien;
        reg_rdata[B_IST]            = ctl_q.main_st;
        reg_rdata[B_SRC]            = ctl_q.src_dma;
        reg_rdata[B_ONE0]           = 1'b1;
        reg_rdata[B_CODE +: CODE_W] = ctl_q.code;
        reg_rdata[B_POST]           = ctl_q.post_sel;
        reg_rdata[B_PRE]            = ctl_q.pre_sel;
        reg_rdata[B_ONE1]           = 1'b1;
        reg_rdata[B_ONE2]           = 1'b1;
        for (int n = 0; n < NTRIG; n++) begin
            reg_rdata[B_TRIG + 2*n]     = ctl_q.trg_en[n];
            reg_rdata[B_TRIG + 2*n + 1] = ctl_q.trg_st[n];
        end
    end

    assign irq_o = (ctl_q.main_st & ctl_q.ien) | (|(ctl_q.trg_st & ctl_q.trg_en));
endmodule

// File: rtl/acq_irq_ctrl_chk.sv
module acq_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [9:0]  cfg_w,
    input logic        dma_done,
    input logic [31:0] reg_rdata,
    input logic        irq_o
);
    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:16] == 16'h0) && reg_rdata[3] && reg_rdata[10] && reg_rdata[11]);

    // R3
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> ({reg_rdata[14], reg_rdata[12], reg_rdata[9:4], reg_rdata[2], reg_rdata[0]}
                    == $past(cfg_w)));

    // R6
    dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && reg_rdata[0] && reg_rdata[2]) |=> reg_rdata[1]);

    // R7
    main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[1]) |-> $past(reg_rdata[0]));

    // R8
    trig0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[13]) |-> $past(reg_rdata[12]));

    // R8
    trig1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[15]) |-> $past(reg_rdata[14]));

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (reg_rdata[1] || reg_rdata[13] || reg_rdata[15]));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && !reg_rdata[12] && !reg_rdata[14]) |-> !irq_o);
endmodule

bind acq_irq_ctrl acq_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .cfg_w     ({reg_wdata[14], reg_wdata[12], reg_wdata[9:4], reg_wdata[2], reg_wdata[0]}),
    .dma_done  (dma_done),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
);

// File: tb/test_acq_irq_ctrl.sv
module test_acq_irq_ctrl;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             dma_done = 1'b0;
    logic [1:0]       ext_trig = '0;
    logic             irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5ns clk = ~clk;

    acq_irq_ctrl #(.CNT_W(CNT_W)) i_acq_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_count(fifo_count), .dma_done(dma_done),
        .ext_trig(ext_trig), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    function automatic int exp_thr(input int code);
        if (code <= 5)      return 32 << code;
        else if (code == 6) return 1536;
        else                return 32;
    endfunction

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 reset value", reg_rdata, 32'h0000_0C08);
        chk("R1 reset irq", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;
        tick(2);

        // R2 / R3: write all ones, status flags are zero so stay zero
        wr(32'hFFFF_FFFF);
        chk("R2 R3 all-ones write", reg_rdata, 32'h0000_5FFD);
        wr(32'h0000_0000);
        chk("R2 zero write", reg_rdata, 32'h0000_0C08);
        // R3 sweep of every config bit pattern on bits 0,2,8,9,12,14 and all codes
        for (int p = 0; p < 64; p++) begin
            logic [31:0] w;
            w = {17'd0, p[5], 1'b0, p[4], 2'b00, p[3], p[2], p[3:0] ^ p[5:2], 1'b0, p[1], 1'b0, p[0]};
            wr(w);
            chk("R3 config readback", reg_rdata, w | 32'h0000_0C08);
        end
        wr(32'h0);

        // R4 threshold sweep over all 16 codes, FIFO mode, enable on
        for (int c = 0; c < 16; c++) begin
            logic [31:0] cfg;
            int t;
            t   = exp_thr(c);
            cfg = 32'h1 | (32'(c) << 4);
            wr(cfg);
            fifo_count = CNT_W'(t - 1);
            tick(2);
            chk("R4 below threshold", {31'd0, reg_rdata[1]}, 32'd0);
            fifo_count = CNT_W'(t);
            tick(1);
            chk("R4 at threshold", {31'd0, reg_rdata[1]}, 32'd1);
            chk("R10 irq on fifo status", {31'd0, irq_o}, 32'd1);
            fifo_count = '0;
            wr(cfg | 32'h2);
            chk("R9 w1c main status", {31'd0, reg_rdata[1]}, 32'd0);
        end

        // R5 once per crossing
        wr(32'h1);
        fifo_count = 12'd40;
        tick(1);
        chk("R5 first crossing", {31'd0, reg_rdata[1]}, 32'd1);
        wr(32'h3);
        tick(4);
        chk("R5 no reset while above", {31'd0, reg_rdata[1]}, 32'd0);
        fifo_count = 12'd10;
        tick(2);
        fifo_count = 12'd40;
        tick(1);
        chk("R5 second crossing", {31'd0, reg_rdata[1]}, 32'd1);
        fifo_count = 12'd10;
        wr(32'h3);
        // R9 set wins over clear on the same edge
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 32'h3; fifo_count = 12'd40;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R9 set beats clear", {31'd0, reg_rdata[1]}, 32'd1);
        fifo_count = '0;
        wr(32'h3);

        // R6 DMA mode
        wr(32'h5);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        chk("R6 dma sets status", {31'd0, reg_rdata[1]}, 32'd1);
        wr(32'h7);
        chk("R9 w1c after dma", {31'd0, reg_rdata[1]}, 32'd0);
        fifo_count = 12'd100;
        tick(3);
        chk("R6 fifo ignored in dma mode", {31'd0, reg_rdata[1]}, 32'd0);
        fifo_count = '0;
        wr(32'h1);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        tick(1);
        chk("R6 dma ignored in fifo mode", {31'd0, reg_rdata[1]}, 32'd0);

        // R7 global enable off
        wr(32'h0);
        fifo_count = 12'd100;
        tick(3);
        chk("R7 fifo gated", {31'd0, reg_rdata[1]}, 32'd0);
        fifo_count = '0;
        wr(32'h4);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        tick(1);
        chk("R7 dma gated", {31'd0, reg_rdata[1]}, 32'd0);
        chk("R7 irq low", {31'd0, irq_o}, 32'd0);

        // R8 trigger 0 latency and gating
        wr(32'h1000);
        @(negedge clk); ext_trig[0] = 1'b1;
        tick(2);
        chk("R8 trig0 not yet", {31'd0, reg_rdata[13]}, 32'd0);
        tick(1);
        chk("R8 trig0 set on third edge", {31'd0, reg_rdata[13]}, 32'd1);
        chk("R8 trig1 untouched", {31'd0, reg_rdata[15]}, 32'd0);
        chk("R10 irq from trig0", {31'd0, irq_o}, 32'd1);
        // R10 clearing enable keeps status
        wr(32'h0);
        chk("R10 irq drops", {31'd0, irq_o}, 32'd0);
        chk("R10 status kept", {31'd0, reg_rdata[13]}, 32'd1);
        wr(32'h1000);
        chk("R10 irq returns", {31'd0, irq_o}, 32'd1);
        wr(32'h3000);
        tick(4);
        chk("R8 held level no reset", {31'd0, reg_rdata[13]}, 32'd0);
        ext_trig[0] = 1'b0;

        // R8 trigger 1 disabled then enabled while high
        wr(32'h0);
        @(negedge clk); ext_trig[1] = 1'b1;
        tick(5);
        chk("R8 trig1 gated", {31'd0, reg_rdata[15]}, 32'd0);
        wr(32'h4000);
        tick(4);
        chk("R8 enable while high", {31'd0, reg_rdata[15]}, 32'd0);
        ext_trig[1] = 1'b0;
        tick(4);
        ext_trig[1] = 1'b1;
        tick(3);
        chk("R8 trig1 set", {31'd0, reg_rdata[15]}, 32'd1);
        wr(32'hC000);
        chk("R9 w1c trig1", {31'd0, reg_rdata[15]}, 32'd0);
        chk("R2 after traffic", reg_rdata & 32'hFFFF_0C08, 32'h0000_0C08);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule